// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master that a processor drives through a small bank of 32-bit registers. The bus is simple and word-aligned. Software sets up the clock rate, polarity and phase in a control register. It sets the chip-select level by hand in a system register. It then writes one byte to the transmit register. That write starts a full-duplex, MSB-first, 8-bit exchange on the serial pins.

Software polls two status bits. The busy bit says that the exchange is still running. The receive-full bit says that a new byte is waiting in the receive register. Reading that register, or writing the status register with bit 2 at zero, clears the receive-full bit.

The serial clock comes from two divider stages. A fixed prescaler divides the input clock by a small or a large factor. Control bit 5 picks which one. A programmable stage then divides the result by 2×(N+1), where N comes from control bits [4:0]. Each half period of the serial clock therefore lasts P×(N+1) input clocks.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control, status, second-control and receive registers read 0 and the system register reads 0x40. The chip-select pin is high and the serial clock is low.
- R2: A write to the transmit register (byte offset 0x0C) starts an exchange when the system register's bit 0 (master enable) is 1 and no exchange is running. Status bit 0 then reads 1 until the exchange ends.
- R3: In each of the four modes (control bit 6 = CPOL, bit 7 = CPHA), the byte is sent MSB first on the data-out pin. The eight bits sampled from the data-in pin end up in the receive register (offset 0x10).
- R4: While idle, the serial clock sits at the CPOL level. An exchange makes exactly 16 clock edges and leaves the clock at that level.
- R5: Status bit 0 stays at 1 for exactly 16×P×(N+1) input clocks after the transmit write. P is PRE_HI when control bit 5 is 1 and PRE_LO when it is 0. N is control bits [4:0].
- R6: Status bit 2 (receive-full) goes to 1 when an exchange completes. A read of the receive register clears it, and so does a write of a value with bit 2 = 0 to the status register (offset 0x04).
- R7: The chip-select pin always equals bit 6 of the system register (offset 0x08). An exchange never changes it.
- R8: A transmit write during an exchange is ignored. The running byte, its duration and its result do not change.
- R9: A control write during an exchange does not change the running exchange's timing. The new value reads back at once.
- R10: With master enable at 0, a transmit write starts nothing. Status bit 0 stays 0 and the serial clock does not toggle.
- R11: The second-control register (offset 0x14) holds and returns the low 8 bits written to it. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Register write strobe |
| busRead | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Register byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Chip select, active low |

## Verification
The bench builds the block with PRE_LO=2 and PRE_HI=4 in place of the default 16 and 128. Every divider setting, including the largest N with the large prescaler, then finishes a byte in at most 2048 clocks. This keeps the exact busy-time count of R5 within reach for both prescaler choices, for many random N values and all four modes. A slave model in the bench shifts data against the master, so each exchange checks both directions of the transfer.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // word index = byte offset >> 2
  localparam int REG_CTRL  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_SYS   = 2;
  localparam int REG_TX    = 3;
  localparam int REG_RX    = 4;
  localparam int REG_CTRL2 = 5;

  // control field positions
  localparam int DIVN_W   = 5;
  localparam int BIT_PRE  = 5;
  localparam int BIT_CPOL = 6;
  localparam int BIT_CPHA = 7;

  typedef struct packed {
    logic load;    // capture transmit byte, clear receive shifter
    logic sample;  // take one bit from the data-in pin
    logic shift;   // advance data-out to the next bit
    logic finish;  // move the assembled byte into the receive buffer
  } engStrobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int FRAME_BITS = 8,
  parameter int PRE_LO     = 16,
  parameter int PRE_HI     = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrite,
  input  logic                  busRead,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [FRAME_BITS-1:0] rxByte,
  output engStrobe_t            strobe,
  output logic                  sclk,
  output logic                  csN,
  output logic                  busy,
  output logic                  rxFull,
  output logic                  masterEn,
  output logic                  idleCpol
);
  localparam int EDGES  = 2 * FRAME_BITS;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int HALF_W = $clog2(PRE_HI * (2 ** DIVN_W)) + 1;
  localparam int IDX_W  = ADDR_W - 2;

  logic [7:0] ctrlReg, sysReg, ctrl2Reg, actCtrl;
  logic [HALF_W-1:0] divCnt, halfLen, preVal, nPlus;
  logic [EDGE_W-1:0] edgeCnt;
  logic sclkLvl, tick, lastEdge, start;
  logic [IDX_W-1:0] idx;
  logic unusedBits;

  assign idx        = busAddr[ADDR_W-1:2];
  assign unusedBits = ^{busWdata, busAddr[1:0]};

  assign start    = busWrite && (idx == IDX_W'(REG_TX)) && !busy && sysReg[0];
  assign preVal   = actCtrl[BIT_PRE] ? HALF_W'(PRE_HI) : HALF_W'(PRE_LO);
  assign nPlus    = HALF_W'(actCtrl[DIVN_W-1:0]) + HALF_W'(1);
  assign halfLen  = preVal * nPlus;
  assign tick     = busy && (divCnt == halfLen - HALF_W'(1));
  assign lastEdge = (edgeCnt == EDGE_W'(EDGES - 1));

  // CPHA=0 samples on leading (even) edges, CPHA=1 on trailing (odd) edges
  always_comb begin
    strobe.load   = start;
    strobe.sample = tick && (edgeCnt[0] == actCtrl[BIT_CPHA]);
    strobe.shift  = tick && (edgeCnt[0] != actCtrl[BIT_CPHA]) &&
                    (edgeCnt != '0) && !lastEdge;
    strobe.finish = tick && lastEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      sysReg   <= 8'h40;
      ctrl2Reg <= '0;
    end else if (busWrite) begin
      case (idx)
        IDX_W'(REG_CTRL):  ctrlReg  <= busWdata[7:0];
        IDX_W'(REG_SYS):   sysReg   <= busWdata[7:0];
        IDX_W'(REG_CTRL2): ctrl2Reg <= busWdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      actCtrl <= '0;
      divCnt  <= '0;
      edgeCnt <= '0;
      sclkLvl <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      actCtrl <= ctrlReg;
      divCnt  <= '0;
      edgeCnt <= '0;
      sclkLvl <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        divCnt  <= '0;
        sclkLvl <= ~sclkLvl;
        edgeCnt <= edgeCnt + EDGE_W'(1);
        if (lastEdge) busy <= 1'b0;
      end else begin
        divCnt <= divCnt + HALF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
    end else if (strobe.finish) begin
      rxFull <= 1'b1;
    end else if (busRead && idx == IDX_W'(REG_RX)) begin
      rxFull <= 1'b0;
    end else if (busWrite && idx == IDX_W'(REG_STAT) && !busWdata[2]) begin
      rxFull <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (idx)
      IDX_W'(REG_CTRL):  busRdata[7:0] = ctrlReg;
      IDX_W'(REG_STAT):  busRdata[2:0] = {rxFull, 1'b0, busy};
      IDX_W'(REG_SYS):   busRdata[7:0] = sysReg;
      IDX_W'(REG_RX):    busRdata[FRAME_BITS-1:0] = rxByte;
      IDX_W'(REG_CTRL2): busRdata[7:0] = ctrl2Reg;
      default: ;
    endcase
  end

  assign idleCpol = ctrlReg[BIT_CPOL];
  assign sclk     = sclkLvl ^ (busy ? actCtrl[BIT_CPOL] : ctrlReg[BIT_CPOL]);
  assign csN      = sysReg[6];
  assign masterEn = sysReg[0];
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  engStrobe_t            strobe,
  input  logic [FRAME_BITS-1:0] txByte,
  input  logic                  miso,
  output logic                  mosi,
  output logic [FRAME_BITS-1:0] rxByte
);
  logic [FRAME_BITS-1:0] txSh, rxSh, rxNext;

  assign rxNext = strobe.sample ? {rxSh[FRAME_BITS-2:0], miso} : rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      rxSh   <= '0;
      rxByte <= '0;
    end else begin
      if (strobe.load) begin
        txSh <= txByte;
        rxSh <= '0;
      end else begin
        if (strobe.shift) txSh <= {txSh[FRAME_BITS-2:0], 1'b0};
        rxSh <= rxNext;
      end
      if (strobe.finish) rxByte <= rxNext;
    end
  end

  assign mosi = txSh[FRAME_BITS-1];
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int FRAME_BITS = 8,
  parameter int PRE_LO     = 16,
  parameter int PRE_HI     = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  engStrobe_t strobe;
  logic [FRAME_BITS-1:0] rxByte;
  logic busy, rxFull, masterEn, idleCpol;

  spim_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS),
    .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxByte(rxByte), .strobe(strobe), .sclk(sclk), .csN(csN),
    .busy(busy), .rxFull(rxFull), .masterEn(masterEn), .idleCpol(idleCpol)
  );

  spim_datapath #(.FRAME_BITS(FRAME_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txByte(busWdata[FRAME_BITS-1:0]), .miso(miso),
    .mosi(mosi), .rxByte(rxByte)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              sclk,
  input logic              csN,
  input logic              busy,
  input logic              rxFull,
  input logic              masterEn
);
  logic txWr, sysWr, ctrlWr;
  assign txWr   = busWrite && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(REG_TX));
  assign sysWr  = busWrite && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(REG_SYS));
  assign ctrlWr = busWrite && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(REG_CTRL));

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(txWr && masterEn));

  // R10
  no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && txWr && !masterEn) |=> !busy);

  // R6
  rxfull_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $fell(busy));

  // R7
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sysWr) |-> $stable(csN));

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !$past(ctrlWr)) |-> $stable(sclk));
endmodule

bind spi_byte_master spim_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
  .sclk(sclk), .csN(csN), .busy(busy), .rxFull(rxFull), .masterEn(masterEn)
);

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int PLO = 2;
  localparam int PHI = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0, busRead = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic sclk, mosi, csN;
  logic miso = 1'b0;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  // slave model state
  bit slvArm = 1'b0, slvCpol = 1'b0, slvCpha = 1'b0;
  logic [7:0] slvTx = '0, slvRx = '0;
  int outIdx = 0, edges = 0, csFlips = 0;

  always #5 clk = ~clk;

  spi_byte_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_BITS(8),
                    .PRE_LO(PLO), .PRE_HI(PHI)) i_spi_byte_master (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  always @(sclk) begin
    if (slvArm) begin
      edges++;
      if ((sclk != slvCpol) ^ slvCpha) slvRx = {slvRx[6:0], mosi};
      else if (outIdx < 8) begin
        miso = slvTx[7 - outIdx];
        outIdx++;
      end
    end
  end

  always @(csN) if (slvArm) csFlips++;

  function automatic int expHalf(input bit pre, input int n);
    return (pre ? PHI : PLO) * (n + 1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // each bus op starts and ends at a falling edge
  task automatic wr(input int idx, input logic [31:0] d);
    busWrite = 1'b1; busAddr = ADDR_W'(idx * 4); busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    busRead = 1'b1; busAddr = ADDR_W'(idx * 4);
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  // midOp: 0 none, 1 transmit write while busy, 2 control write while busy
  task automatic xfer(input bit cpol, input bit cpha, input bit pre, input int n,
                      input logic [7:0] txb, input logic [7:0] slvb,
                      input int midOp, input logic [7:0] midVal, input string tag);
    logic [31:0] v;
    int busyCnt, h;
    h = expHalf(pre, n);
    wr(0, {24'd0, cpha, cpol, pre, n[4:0]});
    slvTx = slvb; slvRx = '0; edges = 0; csFlips = 0;
    slvCpol = cpol; slvCpha = cpha; outIdx = 0;
    if (!cpha) begin miso = slvb[7]; outIdx = 1; end
    slvArm = 1'b1;
    wr(3, {24'd0, txb});
    busyCnt = 0;
    v = '0;
    for (int g = 0; g < 5000; g++) begin
      if (midOp != 0 && busyCnt == 5) begin
        wr(midOp == 1 ? 3 : 0, {24'd0, midVal});
        busyCnt++;
      end else begin
        rd(1, v);
        if (v[0]) busyCnt++;
        else break;
      end
    end
    slvArm = 1'b0;
    check(busyCnt == 16 * h, {"R5 busy length ", tag}, busyCnt, 16 * h);
    check(edges == 16, {"R4 edge count ", tag}, edges, 16);
    check(sclk == cpol, {"R4 idle level ", tag}, sclk, cpol);
    check(slvRx == txb, {"R3 slave got ", tag}, slvRx, txb);
    check(csFlips == 0, {"R7 cs steady ", tag}, csFlips, 0);
    check(v[2] == 1'b1, {"R6 rxfull set ", tag}, v[2], 1);
    rd(4, v);
    check(v == {24'd0, slvb}, {"R3 master got ", tag}, v, slvb);
    rd(1, v);
    check(v[2] == 1'b0, {"R6 cleared by read ", tag}, v[2], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    // R1 reset values
    check(csN == 1'b1, "R1 csN", csN, 1);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    rstN = 1'b1;
    @(negedge clk);
    rd(0, v); check(v == 0, "R1 control", v, 0);
    rd(1, v); check(v == 0, "R1 status", v, 0);
    rd(2, v); check(v == 32'h40, "R1 system", v, 32'h40);
    rd(4, v); check(v == 0, "R1 receive", v, 0);
    rd(5, v); check(v == 0, "R1 control2", v, 0);

    // R10 transmit with master disabled
    edges = 0; slvArm = 1'b1;
    wr(3, 32'hA5);
    repeat (40) @(negedge clk);
    slvArm = 1'b0;
    rd(1, v); check(v[0] == 1'b0, "R10 busy stays 0", v, 0);
    check(edges == 0, "R10 no clock edges", edges, 0);

    // R7 chip select follows system bit 6
    wr(2, 32'h21);
    check(csN == 1'b0, "R7 cs asserted", csN, 0);
    wr(2, 32'h61);
    check(csN == 1'b1, "R7 cs released", csN, 1);
    wr(2, 32'h21);

    // R11 second control and unmapped
    wr(5, 32'hFFFF_FF3C);
    rd(5, v); check(v == 32'h3C, "R11 control2 readback", v, 32'h3C);
    rd(6, v); check(v == 0, "R11 unmapped offset", v, 0);

    // R3/R4 directed four modes
    xfer(0, 0, 0, 0, 8'hA5, 8'h3C, 0, 0, "mode0");
    xfer(1, 0, 0, 1, 8'h81, 8'h7E, 0, 0, "mode2");
    xfer(0, 1, 1, 0, 8'h01, 8'h80, 0, 0, "mode1");
    xfer(1, 1, 1, 2, 8'hFE, 8'h55, 0, 0, "mode3");
    // R5 largest divider
    xfer(0, 0, 1, 31, 8'hC3, 8'h96, 0, 0, "N31 big prescale");

    // R8 transmit while busy ignored
    xfer(0, 1, 0, 2, 8'h5A, 8'hE1, 1, 8'h00, "R8 tx while busy");
    // R9 control while busy: timing unchanged, readback new
    xfer(1, 0, 0, 1, 8'h33, 8'hCC, 2, 8'h4F, "R9 ctrl while busy");
    rd(0, v); check(v == 32'h4F, "R9 new control readback", v, 32'h4F);

    // R6 clear via status write
    xfer(0, 0, 0, 0, 8'h12, 8'h34, 0, 0, "pre R6");
    xfer(0, 0, 0, 0, 8'h56, 8'h78, 0, 0, "pre R6b");
    wr(4 - 1, 32'h0);  // dummy transmit starts byte 0x00
    for (int g = 0; g < 200; g++) begin rd(1, v); if (!v[0]) break; end
    rd(1, v); check(v[2] == 1'b1, "R6 set before status write", v[2], 1);
    wr(1, 32'h0);
    rd(1, v); check(v[2] == 1'b0, "R6 cleared by status write", v[2], 0);

    // random mix
    for (int k = 0; k < 24; k++) begin
      logic [31:0] r;
      r = $urandom;
      xfer(r[0], r[1], r[2], int'(r[5:3]), r[15:8], r[23:16], 0, 0, "random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule